// File: doc/BRIEF.md
# Segmented Packet Buffer Manager

This block keeps track of where packets live in a shared packet store that is cut into fixed slots of 128 bytes. Any slot can belong to any flow. Slots not in use sit on a linked free chain. Each flow owns a linked queue of slots, and only the queue's first and last slot numbers are held per flow. One table of successor pointers, with one entry per slot, links both the free chain and every flow queue. The block hands out slot numbers only. Moving the packet bytes in and out of the store is left to the surrounding logic.

An enqueue request gives a flow number and a byte length. The block works out how many slots the packet needs, checks that enough are free, and then pops them off the free chain one per cycle. Each popped slot is appended to the flow's queue and reported on the output. A dequeue request gives a flow number. The block returns the oldest slot of that flow, puts the slot back at the end of the free chain, and advances the flow's first pointer. The controller has two states. In ST_IDLE it accepts one request. In ST_ALLOC it hands out one slot per cycle. Two transitions join them: T_START goes from ST_IDLE to ST_ALLOC when an enqueue is granted, and T_FINISH goes from ST_ALLOC to ST_IDLE on the last slot. A refused enqueue and every dequeue are completed inside ST_IDLE without leaving it.

Top module: `segbuf_mgr`

## Requirements
- R1: After reset, free_count equals NUM_SEGS (256), ready is 1, and seg_valid, enq_done, enq_err, deq_valid and deq_err are all 0.
- R2: An accepted enqueue of length L produces ceil(L/128) seg_valid pulses on consecutive cycles. The first pulse comes two cycles after the request edge. enq_done is high together with the last pulse, and ready stays 0 from the cycle after the request edge until that last pulse.
- R3: Slots are issued from the front of the free chain. After reset the chain holds slots 0, 1, 2 and onward in ascending order. A released slot joins the back of the chain.
- R4: An enqueue whose length is 0, or which needs more slots than free_count, pulses enq_err one cycle after the request. No slot is issued and free_count is unchanged.
- R5: A dequeue of a non-empty flow pulses deq_valid one cycle after the request, with deq_addr set to that flow's oldest slot, and free_count rises by one.
- R6: A dequeue of an empty flow pulses deq_err one cycle after the request and leaves free_count unchanged.
- R7: free_count falls by exactly one with each issued slot, and it can reach 0.
- R8: When enq_req and deq_req are both high in ST_IDLE, only the enqueue is served. While ready is 0, deq_req has no effect, and the flow's queue is left intact for a later dequeue.
- R9: Flows are independent. Interleaved enqueues to different flows return, per flow, that flow's own slots in the order they were issued.
- R10: Once its last slot is dequeued, a flow is empty, and a further dequeue of it gives deq_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_req | input | 1 | Enqueue request, sampled when ready is 1 |
| enq_flow | input | FLOW_W (3) | Flow to append to |
| enq_len | input | LEN_W (16) | Packet length in bytes |
| deq_req | input | 1 | Dequeue request, sampled when ready is 1 and enq_req is 0 |
| deq_flow | input | FLOW_W (3) | Flow to take the oldest slot from |
| ready | output | 1 | Controller is in ST_IDLE |
| seg_valid | output | 1 | A slot was issued this cycle |
| seg_addr | output | SEG_W (8) | Issued slot number |
| enq_done | output | 1 | Last slot of the enqueue |
| enq_err | output | 1 | Enqueue refused |
| deq_valid | output | 1 | Dequeue served |
| deq_addr | output | SEG_W (8) | Slot released by the dequeue |
| deq_err | output | 1 | Dequeue of an empty flow |
| free_count | output | CNT_W (9) | Number of free slots |

## Verification
Every outcome is registered. A request made at clock edge k shows its enq_err, deq_valid or deq_err after edge k+1. The i-th slot of an accepted enqueue shows after edge k+1+i. The bench drives inputs on falling edges and samples on the falling edge after each counted rising edge. For each request it waits exactly that many edges, so every check lands on the cycle its result is due. A queue model of the free chain and of each flow supplies the expected slot numbers and counts. During enqueues that are also given a dequeue, the bench checks every allocation cycle for a stray dequeue result.

// File: rtl/segbuf_pkg.sv
package segbuf_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ALLOC = 1'b1
    } mgr_state_e;
endpackage

// File: rtl/segbuf_link.sv
// Successor pointer per slot; shared by the free chain and all flow queues.
module segbuf_link #(
    parameter int NUM_SEGS = 256,
    parameter int SEG_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic [SEG_W-1:0] wr_nxt,
    input  logic [SEG_W-1:0] rd_a_idx,
    output logic [SEG_W-1:0] rd_a_nxt,
    input  logic [SEG_W-1:0] rd_b_idx,
    output logic [SEG_W-1:0] rd_b_nxt
);
    logic [SEG_W-1:0] nxt_q [NUM_SEGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SEGS; i++) begin
                nxt_q[i] <= SEG_W'((i + 1) % NUM_SEGS);
            end
        end else if (wr_en) begin
            nxt_q[wr_idx] <= wr_nxt;
        end
    end

    assign rd_a_nxt = nxt_q[rd_a_idx];
    assign rd_b_nxt = nxt_q[rd_b_idx];
endmodule

// File: rtl/segbuf_free.sv
// Front, back and population of the free chain.
module segbuf_free #(
    parameter int NUM_SEGS = 256,
    parameter int SEG_W    = 8,
    parameter int CNT_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  logic             push,
    input  logic [SEG_W-1:0] push_seg,
    input  logic [SEG_W-1:0] head_nxt,
    output logic [SEG_W-1:0] head_seg,
    output logic [SEG_W-1:0] tail_seg,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_seg <= '0;
            tail_seg <= SEG_W'(NUM_SEGS - 1);
            count    <= CNT_W'(NUM_SEGS);
        end else if (pop) begin
            head_seg <= head_nxt;
            count    <= count - CNT_W'(1);
        end else if (push) begin
            tail_seg <= push_seg;
            if (count == '0) begin
                head_seg <= push_seg;
            end
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/segbuf_flows.sv
// Per-flow first/last slot and occupancy flag.
module segbuf_flows #(
    parameter int NUM_FLOWS = 8,
    parameter int FLOW_W    = 3,
    parameter int SEG_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLOW_W-1:0] op_flow,
    input  logic              app_en,
    input  logic [SEG_W-1:0]  app_seg,
    input  logic              rem_en,
    input  logic [SEG_W-1:0]  rem_nxt,
    output logic [SEG_W-1:0]  fl_head,
    output logic [SEG_W-1:0]  fl_tail,
    output logic              fl_vld
);
    logic [SEG_W-1:0] head_q [NUM_FLOWS];
    logic [SEG_W-1:0] tail_q [NUM_FLOWS];
    logic [NUM_FLOWS-1:0] vld_q;

    for (genvar g = 0; g < NUM_FLOWS; g++) begin : g_flow
        logic hit;
        assign hit = (op_flow == FLOW_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                head_q[g] <= '0;
                tail_q[g] <= '0;
                vld_q[g]  <= 1'b0;
            end else if (hit && app_en) begin
                tail_q[g] <= app_seg;
                if (!vld_q[g]) begin
                    head_q[g] <= app_seg;
                    vld_q[g]  <= 1'b1;
                end
            end else if (hit && rem_en) begin
                if (head_q[g] == tail_q[g]) begin
                    vld_q[g] <= 1'b0;
                end else begin
                    head_q[g] <= rem_nxt;
                end
            end
        end
    end

    assign fl_head = head_q[op_flow];
    assign fl_tail = tail_q[op_flow];
    assign fl_vld  = vld_q[op_flow];
endmodule

// File: rtl/segbuf_mgr.sv
module segbuf_mgr
    import segbuf_pkg::*;
#(
    parameter int NUM_SEGS  = 256,
    parameter int NUM_FLOWS = 8,
    parameter int SEG_BYTES = 128,
    parameter int LEN_W     = 16,
    localparam int SEG_W    = $clog2(NUM_SEGS),
    localparam int FLOW_W   = $clog2(NUM_FLOWS),
    localparam int CNT_W    = $clog2(NUM_SEGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_req,
    input  logic [FLOW_W-1:0] enq_flow,
    input  logic [LEN_W-1:0]  enq_len,
    input  logic              deq_req,
    input  logic [FLOW_W-1:0] deq_flow,
    output logic              ready,
    output logic              seg_valid,
    output logic [SEG_W-1:0]  seg_addr,
    output logic              enq_done,
    output logic              enq_err,
    output logic              deq_valid,
    output logic [SEG_W-1:0]  deq_addr,
    output logic              deq_err,
    output logic [CNT_W-1:0]  free_count
);
    localparam int SHIFT = $clog2(SEG_BYTES);

    mgr_state_e state_q, state_d;
    logic [FLOW_W-1:0] cur_flow_q;
    logic [LEN_W:0]    remain_q;
    logic [LEN_W:0]    need_w;
    logic              fits, idle, alloc, last;
    logic              accept_enq, reject_enq, deq_try, do_deq, deq_miss;

    logic [FLOW_W-1:0] op_flow;
    logic [SEG_W-1:0]  fl_head, fl_tail, free_head, free_tail;
    logic              fl_vld;
    logic [SEG_W-1:0]  free_nxt, head_nxt;
    logic              lk_we;
    logic [SEG_W-1:0]  lk_idx, lk_val;

    // Slots needed: ceil(len / SEG_BYTES)
    assign need_w = ({1'b0, enq_len} + (LEN_W+1)'(SEG_BYTES - 1)) >> SHIFT;
    assign fits   = (need_w != '0) && (32'(need_w) <= 32'(free_count));

    assign idle       = (state_q == ST_IDLE);
    assign alloc      = (state_q == ST_ALLOC);
    assign last       = alloc && (remain_q == (LEN_W+1)'(1));
    assign accept_enq = idle && enq_req && fits;
    assign reject_enq = idle && enq_req && !fits;
    assign deq_try    = idle && !enq_req && deq_req;
    assign do_deq     = deq_try && fl_vld;
    assign deq_miss   = deq_try && !fl_vld;
    assign op_flow    = alloc ? cur_flow_q : deq_flow;
    assign ready      = idle;

    // One link write per cycle: flow append or free-chain append
    always_comb begin
        lk_we  = 1'b0;
        lk_idx = fl_tail;
        lk_val = free_head;
        if (alloc && fl_vld) begin
            lk_we  = 1'b1;
            lk_idx = fl_tail;
            lk_val = free_head;
        end else if (do_deq && (free_count != '0)) begin
            lk_we  = 1'b1;
            lk_idx = free_tail;
            lk_val = fl_head;
        end
    end

    segbuf_link #(.NUM_SEGS(NUM_SEGS), .SEG_W(SEG_W)) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (lk_we),
        .wr_idx   (lk_idx),
        .wr_nxt   (lk_val),
        .rd_a_idx (free_head),
        .rd_a_nxt (free_nxt),
        .rd_b_idx (fl_head),
        .rd_b_nxt (head_nxt)
    );

    segbuf_free #(.NUM_SEGS(NUM_SEGS), .SEG_W(SEG_W), .CNT_W(CNT_W)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (alloc),
        .push     (do_deq),
        .push_seg (fl_head),
        .head_nxt (free_nxt),
        .head_seg (free_head),
        .tail_seg (free_tail),
        .count    (free_count)
    );

    segbuf_flows #(.NUM_FLOWS(NUM_FLOWS), .FLOW_W(FLOW_W), .SEG_W(SEG_W)) u_flows (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_flow (op_flow),
        .app_en  (alloc),
        .app_seg (free_head),
        .rem_en  (do_deq),
        .rem_nxt (head_nxt),
        .fl_head (fl_head),
        .fl_tail (fl_tail),
        .fl_vld  (fl_vld)
    );

    // Next state: T_START and T_FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept_enq) state_d = ST_ALLOC;
            ST_ALLOC: if (last)       state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_flow_q <= '0;
            remain_q   <= '0;
        end else if (accept_enq) begin
            cur_flow_q <= enq_flow;
            remain_q   <= need_w;
        end else if (alloc) begin
            remain_q   <= remain_q - (LEN_W+1)'(1);
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_valid <= 1'b0;
            seg_addr  <= '0;
            enq_done  <= 1'b0;
            enq_err   <= 1'b0;
            deq_valid <= 1'b0;
            deq_addr  <= '0;
            deq_err   <= 1'b0;
        end else begin
            seg_valid <= alloc;
            enq_done  <= last;
            enq_err   <= reject_enq;
            deq_valid <= do_deq;
            deq_err   <= deq_miss;
            if (alloc)  seg_addr <= free_head;
            if (do_deq) deq_addr <= fl_head;
        end
    end
endmodule

// File: rtl/segbuf_mgr_chk.sv
module segbuf_mgr_chk #(
    parameter int NUM_SEGS = 256,
    parameter int CNT_W    = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready,
    input logic             seg_valid,
    input logic             enq_done,
    input logic             enq_err,
    input logic             deq_valid,
    input logic             deq_err,
    input logic [CNT_W-1:0] free_count
);
    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(free_count) <= NUM_SEGS);                                          // R7
    AST_SEG_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> free_count == $past(free_count) - CNT_W'(1));            // R7
    AST_SEG_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !enq_done |=> seg_valid);                                 // R2
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid && !enq_done |-> !ready);                                    // R2
    AST_ERR_NO_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        enq_err |-> !seg_valid && $stable(free_count));                        // R4
    AST_DEQ_INC: assert property (@(posedge clk) disable iff (!rst_n)
        deq_valid |-> free_count == $past(free_count) + CNT_W'(1));            // R5
    AST_MISS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        deq_err |-> $stable(free_count));                                      // R6
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seg_valid, enq_err, deq_valid, deq_err}));                   // R8
endmodule

bind segbuf_mgr segbuf_mgr_chk #(.NUM_SEGS(NUM_SEGS), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .seg_valid  (seg_valid),
    .enq_done   (enq_done),
    .enq_err    (enq_err),
    .deq_valid  (deq_valid),
    .deq_err    (deq_err),
    .free_count (free_count)
);

// File: tb/test_segbuf_mgr.sv
module test_segbuf_mgr;
    localparam int NS  = 256;
    localparam int NF  = 8;
    localparam int SB  = 128;
    localparam int NV  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enq_req = 1'b0, deq_req = 1'b0;
    logic [2:0] enq_flow = '0, deq_flow = '0;
    logic [15:0] enq_len = '0;
    logic ready, seg_valid, enq_done, enq_err, deq_valid, deq_err;
    logic [7:0] seg_addr, deq_addr;
    logic [8:0] free_count;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    int free_q[$];
    int flq[NF][$];

    // {is_enq, flow[2:0], len[15:0]}
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 3'd0, 16'd100}, {1'b1, 3'd1, 16'd300}, {1'b1, 3'd0, 16'd129},
        {1'b0, 3'd0, 16'd0},   {1'b0, 3'd2, 16'd0},   {1'b1, 3'd2, 16'd128},
        {1'b0, 3'd1, 16'd0},   {1'b0, 3'd0, 16'd0},   {1'b1, 3'd3, 16'd0},
        {1'b0, 3'd0, 16'd0},   {1'b0, 3'd2, 16'd0},   {1'b0, 3'd0, 16'd0}
    };

    always #5ns clk = ~clk;

    segbuf_mgr i_segbuf_mgr (
        .clk(clk), .rst_n(rst_n),
        .enq_req(enq_req), .enq_flow(enq_flow), .enq_len(enq_len),
        .deq_req(deq_req), .deq_flow(deq_flow),
        .ready(ready), .seg_valid(seg_valid), .seg_addr(seg_addr),
        .enq_done(enq_done), .enq_err(enq_err),
        .deq_valid(deq_valid), .deq_addr(deq_addr), .deq_err(deq_err),
        .free_count(free_count)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_enq(input int f, input int len, input bit with_deq, input int dq_f);
        int need = (len + SB - 1) / SB;
        bit bad  = (need == 0) || (need > free_q.size());
        int fc0  = free_q.size();
        @(negedge clk);
        enq_req = 1'b1; enq_flow = 3'(f); enq_len = 16'(len);
        deq_req = with_deq; deq_flow = 3'(dq_f);
        @(negedge clk);
        enq_req = 1'b0;
        if (bad) begin
            deq_req = 1'b0;
            check("R4 enq_err", int'(enq_err), 1);
            check("R4 no seg", int'(seg_valid), 0);
            check("R4 free_count", int'(free_count), fc0);
            check("R8 no deq", int'(deq_valid | deq_err), 0);
        end else begin
            check("R2 ready low", int'(ready), 0);
            check("R8 no deq", int'(deq_valid | deq_err), 0);
            for (int i = 0; i < need; i++) begin
                @(negedge clk);
                if (i == need - 1) deq_req = 1'b0;
                check("R2 seg_valid", int'(seg_valid), 1);
                check("R3 seg_addr", int'(seg_addr), free_q[0]);
                check("R2 enq_done", int'(enq_done), int'(i == need - 1));
                check("R7 free_count", int'(free_count), free_q.size() - 1);
                if (with_deq) check("R8 deq ignored", int'(deq_valid | deq_err), 0);
                flq[f].push_back(free_q.pop_front());
            end
        end
    endtask

    task automatic run_deq(input int f, input string tag);
        int fc0 = free_q.size();
        @(negedge clk);
        deq_req = 1'b1; deq_flow = 3'(f);
        @(negedge clk);
        deq_req = 1'b0;
        if (flq[f].size() == 0) begin
            check({tag, " deq_err"}, int'(deq_err), 1);
            check({tag, " no deq_valid"}, int'(deq_valid), 0);
            check({tag, " free_count"}, int'(free_count), fc0);
        end else begin
            int exp = flq[f].pop_front();
            check("R5 deq_valid", int'(deq_valid), 1);
            check({tag, " deq_addr"}, int'(deq_addr), exp);
            check("R5 free_count", int'(free_count), fc0 + 1);
            free_q.push_back(exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) free_q.push_back(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 free_count", int'(free_count), NS);
        check("R1 ready", int'(ready), 1);
        check("R1 outputs idle", int'({seg_valid, enq_done, enq_err, deq_valid, deq_err}), 0);

        // Table walk: R2 R3 R4 R5 R6 R9 R10
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][19]) run_enq(int'(VEC[v][18:16]), int'(VEC[v][15:0]), 1'b0, 0);
            else            run_deq(int'(VEC[v][18:16]), (v == 4) ? "R6" : (v == 11) ? "R10" : "R9");
        end

        // R8: simultaneous and busy-time dequeue is ignored; flow 1 kept intact
        run_enq(4, 200, 1'b1, 1);
        run_deq(1, "R8");
        // R4: oversize
        run_enq(3, 65535, 1'b0, 0);
        // R7: fill to zero
        run_enq(5, free_q.size() * SB, 1'b0, 0);
        check("R7 empty pool", int'(free_count), 0);
        run_enq(6, 1, 1'b0, 0);
        // R3: released slot reused from back of chain
        run_deq(5, "R9");
        run_enq(6, 1, 1'b0, 0);
        // R10: drain flow 5
        while (flq[5].size() > 0) run_deq(5, "R9");
        run_deq(5, "R10");
        check("R7 final free_count", int'(free_count), free_q.size());

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule